// File: doc/BRIEF.md
# Framebuffer Control Registers with End-of-Frame Interrupt

This block is the register file that a processor uses to steer a simple framebuffer controller. It decodes a 32-byte window. At offset 0x10 sits a control byte whose bit 7 enables an end-of-frame interrupt. At offset 0x11 sits a status byte. It reports a live pending flag in bit 7, ORed with fixed identification bits: 0x60 gives the monitor sense code and 0x01 marks a colour board. The offsets from 0x12 up to the top of the window are plain byte storage for the cursor and video timing bytes, starting with cursor start at 0x12, cursor end at 0x13 and video control at 0x14.

The display pipeline pulses `frame_end` once per frame. When the enable bit is set, that pulse moves the interrupt tracker from the idle state to the pending state, and the `irq` output rises. Software acknowledges the interrupt by writing any value to the status offset, which returns the tracker to idle. Reads are combinational on the address. Writes take effect on the next rising clock edge.

The interrupt tracker has two states. IRQ_IDLE moves to IRQ_PENDING on the transition "frame raise", which is a frame pulse while interrupts are enabled. IRQ_PENDING moves to IRQ_IDLE on the transition "acknowledge", which is a status write with no frame raise in the same cycle. When both a frame raise and a status write occur in the same cycle, the tracker takes the transition "raise over ack" and stays in IRQ_PENDING. In every other case each state holds.

Top module: `fbc_ctrl_regs`

## Requirements
- R1: While reset is asserted, and right after it is released, `irq` is 0, control (0x10) reads 0x00 and status (0x11) reads 0x61.
- R2: A write to offset 0x10 stores the byte. Control reads back exactly the last value written.
- R3: A read of offset 0x11 returns 0x61 ORed with the pending flag placed in bit 7. So it reads 0x61 when idle and 0xE1 when pending.
- R4: A `frame_end` pulse while control bit 7 is 1 sets the pending flag. `irq` is 1 from the next clock edge on.
- R5: A `frame_end` pulse while control bit 7 is 0 has no effect. `irq` and the status byte stay unchanged.
- R6: A write of any value to offset 0x11 while pending clears the flag. `irq` is 0 after that edge. The same write while idle leaves `irq` at 0.
- R7: When an enabled `frame_end` and a status write land in the same cycle, the flag ends up set and `irq` is 1.
- R8: Offsets 0x12 through 0x1F are byte storage. Each one reads back the last value written to that offset.
- R9: Offsets 0x00 through 0x0F read 0x00. Writes to them change no register and do not change `irq`.
- R10: `irq` always equals bit 7 of the status read.
- R11: Clearing control bit 7 while pending does not clear the pending flag.
- R12: A status write does not change control or the storage bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the current address |
| reg_addr | input | 5 | Byte offset within the register window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| frame_end | input | 1 | One-cycle pulse at the end of each frame |
| irq | output | 1 | Interrupt level, equal to the pending flag |

## Verification
The checker evaluates the following on every cycle: the state transitions "frame raise", "acknowledge" and "raise over ack"; the rule that `irq` holds in all other cases; the constant identification bits; the mirror between `irq` and status bit 7; and the zero reads below 0x10. Several properties can only be shown by the bench's scenarios, because they depend on data written earlier: that a byte written long ago still reads back, that unimplemented writes leave every other register intact, that an acknowledge leaves control and storage untouched, and that disabling interrupts keeps a pending flag. The bench runs directed sequences and then a long seeded random mix, comparing against a reference model of the register file.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int FBC_ADDR_W = 5;
    localparam int FBC_DATA_W = 8;

    // Offsets that software and the display pipeline rely on
    localparam logic [FBC_ADDR_W-1:0] OFS_CTRL     = 5'h10;
    localparam logic [FBC_ADDR_W-1:0] OFS_STAT     = 5'h11;
    localparam logic [FBC_ADDR_W-1:0] OFS_STORE_LO = 5'h12;

    // Bit positions in control and status
    localparam int CTRL_IRQ_EN_BIT = 7;
    localparam int STAT_PEND_BIT   = 7;

    // Fixed identification bits: monitor sense 0x60, colour board 0x01
    localparam logic [FBC_DATA_W-1:0] STAT_ID_BITS = 8'h61;

    typedef enum logic {
        IRQ_IDLE    = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_e;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_STAT  = 2'd2,
        SEL_STORE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/fbc_addr_decode.sv
module fbc_addr_decode
    import fbc_pkg::*;
#(
    parameter int ADDR_W  = FBC_ADDR_W,
    parameter int STORE_N = (1 << ADDR_W) - 18,
    parameter int IDX_W   = (STORE_N > 1) ? $clog2(STORE_N) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  store_idx
);

    logic [ADDR_W-1:0] offset_from_store;

    always_comb begin
        offset_from_store = addr - OFS_STORE_LO;
        store_idx         = offset_from_store[IDX_W-1:0];
    end

    always_comb begin
        if (addr == OFS_CTRL) begin
            sel = SEL_CTRL;
        end else if (addr == OFS_STAT) begin
            sel = SEL_STAT;
        end else if (addr >= OFS_STORE_LO) begin
            sel = SEL_STORE;
        end else begin
            sel = SEL_NONE;
        end
    end

endmodule

// File: rtl/fbc_reg_bank.sv
module fbc_reg_bank
    import fbc_pkg::*;
#(
    parameter int DATA_W  = FBC_DATA_W,
    parameter int STORE_N = 14,
    parameter int IDX_W   = (STORE_N > 1) ? $clog2(STORE_N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  reg_sel_e                  sel,
    input  logic [IDX_W-1:0]          store_idx,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         ctrl_q,
    output logic [STORE_N*DATA_W-1:0] store_flat
);

    logic ctrl_we;

    always_comb begin
        ctrl_we = wr && (sel == SEL_CTRL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= wdata;
        end
    end

    for (genvar g = 0; g < STORE_N; g++) begin : g_store
        logic byte_we;
        logic [DATA_W-1:0] byte_q;

        always_comb begin
            byte_we = wr && (sel == SEL_STORE) && (store_idx == IDX_W'(g));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (byte_we) begin
                byte_q <= wdata;
            end
        end

        assign store_flat[g*DATA_W +: DATA_W] = byte_q;
    end

endmodule

// File: rtl/fbc_irq_fsm.sv
module fbc_irq_fsm
    import fbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic irq_en,
    input  logic stat_wr,
    output logic irq_pending
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       frame_raise;

    always_comb begin
        frame_raise = frame_end && irq_en;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (frame_raise) begin
                    state_d = IRQ_PENDING;          // frame raise
                end
            end
            IRQ_PENDING: begin
                if (frame_raise) begin
                    state_d = IRQ_PENDING;          // raise over ack
                end else if (stat_wr) begin
                    state_d = IRQ_IDLE;             // acknowledge
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            IRQ_PENDING: irq_pending = 1'b1;
            default:     irq_pending = 1'b0;
        endcase
    end

endmodule

// File: rtl/fbc_read_mux.sv
module fbc_read_mux
    import fbc_pkg::*;
#(
    parameter int DATA_W  = FBC_DATA_W,
    parameter int STORE_N = 14,
    parameter int IDX_W   = (STORE_N > 1) ? $clog2(STORE_N) : 1
) (
    input  reg_sel_e                  sel,
    input  logic [IDX_W-1:0]          store_idx,
    input  logic [DATA_W-1:0]         ctrl_q,
    input  logic                      irq_pending,
    input  logic [STORE_N*DATA_W-1:0] store_flat,
    output logic [DATA_W-1:0]         rdata
);

    logic [DATA_W-1:0] store_byte;
    logic [DATA_W-1:0] stat_byte;

    always_comb begin
        store_byte = store_flat[store_idx*DATA_W +: DATA_W];
        stat_byte  = STAT_ID_BITS;
        stat_byte[STAT_PEND_BIT] = irq_pending;
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL:  rdata = ctrl_q;
            SEL_STAT:  rdata = stat_byte;
            SEL_STORE: rdata = store_byte;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/fbc_ctrl_regs.sv
module fbc_ctrl_regs
    import fbc_pkg::*;
#(
    parameter int ADDR_W = FBC_ADDR_W,
    parameter int DATA_W = FBC_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_end,
    output logic              irq
);

    localparam int WINDOW_BYTES = 1 << ADDR_W;
    localparam int STORE_N      = WINDOW_BYTES - int'(OFS_STORE_LO);
    localparam int IDX_W        = (STORE_N > 1) ? $clog2(STORE_N) : 1;

    reg_sel_e                  sel;
    logic [IDX_W-1:0]          store_idx;
    logic [DATA_W-1:0]         ctrl_q;
    logic [STORE_N*DATA_W-1:0] store_flat;
    logic                      irq_en;
    logic                      stat_wr;
    logic                      irq_pending;

    fbc_addr_decode #(
        .ADDR_W  (ADDR_W),
        .STORE_N (STORE_N),
        .IDX_W   (IDX_W)
    ) u_decode (
        .addr      (reg_addr),
        .sel       (sel),
        .store_idx (store_idx)
    );

    fbc_reg_bank #(
        .DATA_W  (DATA_W),
        .STORE_N (STORE_N),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .sel        (sel),
        .store_idx  (store_idx),
        .wdata      (reg_wdata),
        .ctrl_q     (ctrl_q),
        .store_flat (store_flat)
    );

    always_comb begin
        irq_en  = ctrl_q[CTRL_IRQ_EN_BIT];
        stat_wr = reg_wr && (sel == SEL_STAT);
    end

    fbc_irq_fsm u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end   (frame_end),
        .irq_en      (irq_en),
        .stat_wr     (stat_wr),
        .irq_pending (irq_pending)
    );

    fbc_read_mux #(
        .DATA_W  (DATA_W),
        .STORE_N (STORE_N),
        .IDX_W   (IDX_W)
    ) u_rmux (
        .sel         (sel),
        .store_idx   (store_idx),
        .ctrl_q      (ctrl_q),
        .irq_pending (irq_pending),
        .store_flat  (store_flat),
        .rdata       (reg_rdata)
    );

    assign irq = irq_pending;

endmodule

// File: rtl/fbc_ctrl_regs_chk.sv
module fbc_ctrl_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [4:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic       frame_end,
    input logic       irq,
    input logic       irq_en
);

    // R4: an enabled frame pulse raises the interrupt
    a_r4_frame_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && irq_en) |=> irq);

    // R6: a status write without a simultaneous raise drops the interrupt
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 5'h11 && !(frame_end && irq_en)) |=> !irq);

    // R7: raise beats acknowledge in the same cycle
    a_r7_raise_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 5'h11 && frame_end && irq_en) |=> irq);

    // R5: with neither raise nor acknowledge the level holds
    a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!(frame_end && irq_en) && !(reg_wr && reg_addr == 5'h11)) |=> $stable(irq));

    // R3: identification bits are constant
    a_r3_status_id: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 5'h11) |-> (reg_rdata[6:0] == 7'h61));

    // R10: status bit 7 mirrors the interrupt line
    a_r10_irq_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 5'h11) |-> (reg_rdata[7] == irq));

    // R9: unimplemented low offsets read zero
    a_r9_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < 5'h10) |-> (reg_rdata == 8'h00));

endmodule

bind fbc_ctrl_regs fbc_ctrl_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .frame_end (frame_end),
    .irq       (irq),
    .irq_en    (irq_en)
);

// File: tb/tb_fbc_ctrl_regs.sv
module tb_fbc_ctrl_regs;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       frame_end;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model
    logic [7:0] m_ctrl;
    logic       m_pend;
    logic [7:0] m_store [32];

    always #5 clk = ~clk;

    fbc_ctrl_regs dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .frame_end (frame_end),
        .irq       (irq)
    );

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        if (a == 5'h10) return m_ctrl;
        if (a == 5'h11) return {m_pend, 7'h61};
        if (a >= 5'h12) return m_store[a];
        return 8'h00;
    endfunction

    function automatic string tag_for(input logic [4:0] a);
        if (a == 5'h10) return "R2";
        if (a == 5'h11) return "R3";
        if (a >= 5'h12) return "R8";
        return "R9";
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 8'h00;
        m_pend = 1'b0;
        for (int i = 0; i < 32; i++) m_store[i] = 8'h00;
    endtask

    task automatic model_step(input logic wr, input logic [4:0] a, input logic [7:0] d, input logic fe);
        logic set_p;
        set_p = fe && m_ctrl[7];
        if (set_p) m_pend = 1'b1;
        else if (wr && a == 5'h11) m_pend = 1'b0;
        if (wr && a == 5'h10) m_ctrl = d;
        if (wr && a >= 5'h12) m_store[a] = d;
    endtask

    // One bus cycle from negedge to negedge
    task automatic cyc(input logic wr, input logic [4:0] a, input logic [7:0] d, input logic fe);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; frame_end = fe;
        @(negedge clk);
        reg_wr = 1'b0; frame_end = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 5'h0; reg_wdata = 8'h0; frame_end = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);

        // R1: reset state, both during and after reset
        chk("R1", {7'b0, irq}, 8'h00);
        peek(5'h10, v); chk("R1", v, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        peek(5'h11, v); chk("R1", v, 8'h61);
        chk("R1", {7'b0, irq}, 8'h00);

        // R2: control readback
        cyc(1'b1, 5'h10, 8'h5A, 1'b0);
        peek(5'h10, v); chk("R2", v, 8'h5A);

        // R5: disabled frame pulse has no effect
        cyc(1'b1, 5'h10, 8'h7F, 1'b0);
        cyc(1'b0, 5'h00, 8'h00, 1'b1);
        chk("R5", {7'b0, irq}, 8'h00);
        peek(5'h11, v); chk("R5", v, 8'h61);

        // R4 / R3 / R10: enabled frame pulse
        cyc(1'b1, 5'h10, 8'h80, 1'b0);
        cyc(1'b0, 5'h00, 8'h00, 1'b1);
        chk("R4", {7'b0, irq}, 8'h01);
        peek(5'h11, v); chk("R3", v, 8'hE1);
        chk("R10", {7'b0, v[7]}, {7'b0, irq});

        // R11: disabling does not clear pending
        cyc(1'b1, 5'h10, 8'h00, 1'b0);
        chk("R11", {7'b0, irq}, 8'h01);

        // R9: low offset write ignored, reads zero
        cyc(1'b1, 5'h05, 8'hFF, 1'b0);
        peek(5'h05, v); chk("R9", v, 8'h00);
        peek(5'h10, v); chk("R9", v, 8'h00);
        chk("R9", {7'b0, irq}, 8'h01);

        // R8: storage set before the acknowledge
        cyc(1'b1, 5'h12, 8'h11, 1'b0);
        cyc(1'b1, 5'h1F, 8'hEE, 1'b0);
        peek(5'h12, v); chk("R8", v, 8'h11);
        peek(5'h1F, v); chk("R8", v, 8'hEE);

        // R6: status write of arbitrary value acknowledges
        cyc(1'b1, 5'h10, 8'hA5, 1'b0);
        cyc(1'b1, 5'h11, 8'h3C, 1'b0);
        chk("R6", {7'b0, irq}, 8'h00);
        peek(5'h11, v); chk("R6", v, 8'h61);
        // R12: acknowledge left control and storage alone
        peek(5'h10, v); chk("R12", v, 8'hA5);
        peek(5'h1F, v); chk("R12", v, 8'hEE);
        // R6: status write when idle keeps irq low
        cyc(1'b1, 5'h11, 8'hFF, 1'b0);
        chk("R6", {7'b0, irq}, 8'h00);

        // R7: raise and acknowledge together
        cyc(1'b1, 5'h11, 8'h80, 1'b1);
        chk("R7", {7'b0, irq}, 8'h01);
        peek(5'h11, v); chk("R7", v, 8'hE1);

        // Random phase against the model
        apply_reset();
        for (int n = 0; n < 3000; n++) begin
            logic       w;
            logic [4:0] a;
            logic [7:0] d;
            logic       fe;
            w  = ($urandom % 3) == 0;
            a  = 5'($urandom % 32);
            if (($urandom % 3) == 0) a = 5'h10 + 5'($urandom % 2);
            d  = 8'($urandom);
            fe = ($urandom % 4) == 0;
            @(negedge clk);
            reg_wr = w; reg_addr = a; reg_wdata = d; frame_end = fe;
            #1;
            chk(tag_for(a), reg_rdata, exp_read(a));
            chk("R10", {7'b0, irq}, {7'b0, m_pend});
            model_step(w, a, d, fe);
        end
        @(negedge clk);
        reg_wr = 1'b0; frame_end = 1'b0;
        chk("R10", {7'b0, irq}, {7'b0, m_pend});

        finish_run();
    end

endmodule